// File: doc/BRIEF.md
# Two-Channel Serial Wiper Code Controller

This block is the digital core of a two-channel programmable resistor with 256 steps per channel. A controller writes it over a three-wire serial port made of a select line, a serial clock and a data line. Each write is a 10-bit frame: two address bits, then an 8-bit wiper code, most significant bit first. When the select line returns high, the code is copied into the wiper latch that the address names. The far end of the internal shift register drives a serial output, so several blocks can share one select and one clock and be written in a single burst.

All serial lines are asynchronous to the block clock. They are oversampled through synchronizer flops and their edges are found in the clock domain, so every timing rule below is counted in block clock cycles. Reset presets both wipers to midscale. A low-active sleep input drives two switch controls per channel: one opens the A terminal and one ties the wiper to the B terminal. Sleep leaves the stored codes alone and does not block writes.

Top module: `dpot_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, both wiper codes become 0x80 (midscale) and `ser_dout` becomes 0.
- R2: A frame is made of the last 10 bits sampled on rising `ser_clk` while `ser_cs_n` is low, first bit received in bit 9. Bit 9 is A1, bit 8 is A0 and bits 7..0 are the code. SYNC_STAGES+2 clock cycles after `ser_cs_n` rises, the code is on the addressed channel's output.
- R3: A0 = 0 writes `wiper_code[7:0]` (channel 0) and A0 = 1 writes `wiper_code[15:8]` (channel 1). The other channel keeps its code. Every one of the 256 codes is accepted on both channels.
- R4: A1 has no effect on which channel is written or on the code that is stored.
- R5: The wiper codes do not change while `ser_cs_n` stays low, however many bits are shifted in.
- R6: When more than 10 bits are shifted in one selection, only the last 10 form the frame.
- R7: `ser_clk` edges while `ser_cs_n` is high leave the shift register untouched. A select pulse with no clock edges commits the frame still held in the register.
- R8: On each falling `ser_clk` while selected, `ser_dout` takes shift-register bit 9, so a bit comes out 10 rising edges after it went in. While `ser_cs_n` is high, `ser_dout` holds its value.
- R9: SYNC_STAGES+1 cycles or more after `sleep_n` goes low, every `term_a_open` and `wiper_to_b` bit is 1. After `sleep_n` has been high for the same time, all of them are 0.
- R10: Entering or leaving sleep leaves the wiper codes unchanged. Frames written during sleep update `wiper_code` while the switch controls stay asserted.
- R11: Two blocks chained through `ser_dout` into the next block's `ser_din`, on a shared select and clock, are both updated by one 20-bit burst whose first 10 bits are for the far block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low; its rising edge commits the frame |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data in, sampled on rising `ser_clk` |
| sleep_n | input | 1 | Low-active sleep request |
| ser_dout | output | 1 | Far end of the shift register, for chaining |
| wiper_code | output | 16 | Channel 1 code in bits 15..8, channel 0 code in bits 7..0 |
| term_a_open | output | 2 | Per channel: open the A terminal |
| wiper_to_b | output | 2 | Per channel: short the wiper to the B terminal |

## Verification
The assertions assume that the serial lines change slowly against `clk`: each level of `ser_cs_n` and `ser_clk` lasts at least SYNC_STAGES+2 cycles, `ser_din` is steady around each rising `ser_clk`, and reset is held for at least two edges. The bench drives every serial phase for five clock cycles, changes data only together with the falling serial clock, and holds reset for five cycles. Under those conditions the checker can bound the synchronizer delay with counters. It then checks that the codes are steady while selected or idle, that at most one channel changes per cycle, and that the sleep controls settle.

// File: rtl/dpot_pkg.sv
// Package: shared constants for the serial wiper controller.
// Assumes nothing beyond elaboration-time evaluation of its function.
package dpot_pkg;
    // Positions of the asynchronous input lines in the synchronizer vector
    localparam int LN_SEL   = 0;
    localparam int LN_SCK   = 1;
    localparam int LN_DIN   = 2;
    localparam int LN_SLEEP = 3;
    localparam int N_LINES  = 4;

    // Width of the channel select field; at least one bit
    function automatic int sel_width(input int n_ch);
        return (n_ch > 1) ? $clog2(n_ch) : 1;
    endfunction
endpackage

// File: rtl/dpot_sync_edge.sv
// Module: multi-flop synchronizer for a vector of asynchronous lines.
// Assumes each line is a level whose changes need no alignment with the
// others beyond what the stage count gives; RST_VAL is the idle level.
module dpot_sync_edge #(
    parameter int W       = 4,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level
);
    logic [W-1:0] stg [STAGES];

    // Shift each raw line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign level = stg[STAGES-1];
endmodule

// File: rtl/dpot_shift_reg.sv
// Module: frame shift register with edge detection and chain output.
// Assumes synchronized inputs whose levels each last at least two clocks.
// Shifts on rising serial clock while selected, launches the far-end bit
// on falling serial clock while selected, and pulses commit on deselect.
module dpot_shift_reg #(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n_lvl,
    input  logic               sck_lvl,
    input  logic               din_lvl,
    output logic [FRAME_W-1:0] frame,
    output logic               commit,
    output logic               dout
);
    logic sck_prev;
    logic sel_prev;
    logic sck_rise;
    logic sck_fall;
    logic [FRAME_W-1:0] frame_q;
    logic dout_q;

    assign sck_rise = sck_lvl & ~sck_prev;
    assign sck_fall = ~sck_lvl & sck_prev;
    assign commit   = sel_n_lvl & ~sel_prev;

    // Remember last levels of serial clock and select for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            sel_prev <= 1'b1;
        end else begin
            sck_prev <= sck_lvl;
            sel_prev <= sel_n_lvl;
        end
    end

    // Shift one bit in at each selected rising serial clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (sck_rise && !sel_n_lvl)
            frame_q <= {frame_q[FRAME_W-2:0], din_lvl};
    end

    // Launch the far-end bit at each selected falling serial clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= 1'b0;
        else if (sck_fall && !sel_n_lvl)
            dout_q <= frame_q[FRAME_W-1];
    end

    assign frame = frame_q;
    assign dout  = dout_q;
endmodule

// File: rtl/dpot_wiper_bank.sv
// Module: per-channel wiper code latches with midscale reset.
// Assumes commit is a single-cycle pulse and sel is stable with it.
// Select values at or above N_CH write nothing.
module dpot_wiper_bank #(
    parameter int N_CH   = 2,
    parameter int CODE_W = 8,
    parameter int SEL_W  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [SEL_W-1:0]         sel,
    input  logic [CODE_W-1:0]        code,
    output logic [N_CH*CODE_W-1:0]   codes
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [CODE_W-1:0] code_q;

        // Load this channel's latch when the committed frame addresses it
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q <= MID;
            else if (commit && (sel == SEL_W'(g)))
                code_q <= code;
        end

        assign codes[g*CODE_W +: CODE_W] = code_q;
    end
endmodule

// File: rtl/dpot_switch_ctl.sv
// Module: per-channel terminal switch controls driven by sleep.
// Assumes sleep_lvl is already synchronized; controls register once more.
module dpot_switch_ctl #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_lvl_n,
    output logic [N_CH-1:0] a_open,
    output logic [N_CH-1:0] w_short
);
    for (genvar g = 0; g < N_CH; g++) begin : g_sw
        // Open A and short wiper to B while sleep is requested; safe at reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_open[g]  <= 1'b1;
                w_short[g] <= 1'b1;
            end else begin
                a_open[g]  <= ~sleep_lvl_n;
                w_short[g] <= ~sleep_lvl_n;
            end
        end
    end
endmodule

// File: rtl/dpot_ctrl.sv
// Module: top of the two-channel serial wiper controller.
// Assumes serial lines are asynchronous and slow against clk (each level
// held at least SYNC_STAGES+2 cycles). Address low bits pick the channel;
// higher address bits are accepted for frame length only.
module dpot_ctrl #(
    parameter int N_CH        = 2,
    parameter int CODE_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_cs_n,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    input  logic                   sleep_n,
    output logic                   ser_dout,
    output logic [N_CH*CODE_W-1:0] wiper_code,
    output logic [N_CH-1:0]        term_a_open,
    output logic [N_CH-1:0]        wiper_to_b
);
    import dpot_pkg::*;

    localparam int FRAME_W = ADDR_W + CODE_W;
    localparam int SEL_W   = sel_width(N_CH);
    localparam logic [N_LINES-1:0] SYNC_RST = N_LINES'(1) << LN_SEL;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic [FRAME_W-1:0] frame;
    logic               commit;

    assign raw_lines[LN_SEL]   = ser_cs_n;
    assign raw_lines[LN_SCK]   = ser_clk;
    assign raw_lines[LN_DIN]   = ser_din;
    assign raw_lines[LN_SLEEP] = sleep_n;

    dpot_sync_edge #(
        .W       (N_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .level (sync_lines)
    );

    dpot_shift_reg #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_lvl (sync_lines[LN_SEL]),
        .sck_lvl   (sync_lines[LN_SCK]),
        .din_lvl   (sync_lines[LN_DIN]),
        .frame     (frame),
        .commit    (commit),
        .dout      (ser_dout)
    );

    // Address bits above the channel select carry no meaning
    if (ADDR_W > SEL_W) begin : g_addr_pad
        logic unused_addr_hi;
        assign unused_addr_hi = ^frame[FRAME_W-1:CODE_W+SEL_W];
    end

    dpot_wiper_bank #(
        .N_CH   (N_CH),
        .CODE_W (CODE_W),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .sel    (frame[CODE_W +: SEL_W]),
        .code   (frame[CODE_W-1:0]),
        .codes  (wiper_code)
    );

    dpot_switch_ctl #(
        .N_CH (N_CH)
    ) u_sw (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_lvl_n (sync_lines[LN_SLEEP]),
        .a_open      (term_a_open),
        .w_short     (wiper_to_b)
    );
endmodule

// File: rtl/dpot_ctrl_chk.sv
// Module: property checker for dpot_ctrl, attached by bind below.
// Assumes reset is held for two or more edges and serial levels last at
// least SYNC_STAGES+2 cycles; counters bound the synchronizer delay.
module dpot_ctrl_chk #(
    parameter int N_CH        = 2,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ser_cs_n,
    input logic                   sleep_n,
    input logic                   ser_dout,
    input logic [N_CH*CODE_W-1:0] wiper_code,
    input logic [N_CH-1:0]        term_a_open,
    input logic [N_CH-1:0]        wiper_to_b
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);
    localparam logic [7:0] LIM     = 8'(SYNC_STAGES + 4);
    localparam logic [7:0] SEL_THR = 8'(SYNC_STAGES + 2);
    localparam logic [7:0] SLP_THR = 8'(SYNC_STAGES + 1);

    logic past_valid = 1'b0;
    logic [7:0] cs_lo_cnt, cs_hi_cnt, sl_lo_cnt, sl_hi_cnt;
    logic [N_CH*CODE_W-1:0] prev_code;
    logic [N_CH-1:0] chg;

    // Mark that one clock edge has been seen
    always_ff @(posedge clk) past_valid <= 1'b1;

    // Keep the previous wiper codes to spot channel changes
    always_ff @(posedge clk) prev_code <= wiper_code;

    // Count consecutive cycles of each level on select and sleep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_lo_cnt <= '0; cs_hi_cnt <= '0;
            sl_lo_cnt <= '0; sl_hi_cnt <= '0;
        end else begin
            cs_lo_cnt <= ser_cs_n  ? 8'd0 : ((cs_lo_cnt < LIM) ? cs_lo_cnt + 8'd1 : cs_lo_cnt);
            cs_hi_cnt <= !ser_cs_n ? 8'd0 : ((cs_hi_cnt < LIM) ? cs_hi_cnt + 8'd1 : cs_hi_cnt);
            sl_lo_cnt <= sleep_n   ? 8'd0 : ((sl_lo_cnt < LIM) ? sl_lo_cnt + 8'd1 : sl_lo_cnt);
            sl_hi_cnt <= !sleep_n  ? 8'd0 : ((sl_hi_cnt < LIM) ? sl_hi_cnt + 8'd1 : sl_hi_cnt);
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_chg
        assign chg[g] = wiper_code[g*CODE_W +: CODE_W] != prev_code[g*CODE_W +: CODE_W];
    end

    AST_RESET_MIDSCALE: assert property (@(posedge clk)
        (past_valid && !$past(rst_n)) |-> (wiper_code == {N_CH{MID}}) && !ser_dout); // R1

    AST_ONE_CHANNEL_PER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg)); // R3

    AST_HOLD_WHILE_SHIFTING: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lo_cnt >= SEL_THR) |-> $stable(wiper_code)); // R5

    AST_DOUT_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= SEL_THR) |-> $stable(ser_dout)); // R8

    AST_SLEEP_ASSERTS_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_lo_cnt >= SLP_THR) |-> (&term_a_open) && (&wiper_to_b)); // R9

    AST_WAKE_RELEASES_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_hi_cnt >= SLP_THR) |-> (term_a_open == '0) && (wiper_to_b == '0)); // R9

    AST_IDLE_CODES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= SEL_THR) |-> $stable(wiper_code)); // R10
endmodule

bind dpot_ctrl dpot_ctrl_chk #(
    .N_CH        (N_CH),
    .CODE_W      (CODE_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_cs_n    (ser_cs_n),
    .sleep_n     (sleep_n),
    .ser_dout    (ser_dout),
    .wiper_code  (wiper_code),
    .term_a_open (term_a_open),
    .wiper_to_b  (wiper_to_b)
);

// File: tb/tb_dpot_ctrl.sv
// Bench: sweeps every code on both channels and walks the frame, chain,
// select and sleep cases, with a second instance chained for R11.
module tb_dpot_ctrl;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic din = 1'b0;
    logic sleep_n = 1'b1;

    logic        dout, dout2;
    logic [15:0] code, code2;
    logic [1:0]  aopen, wshort, aopen2, wshort2;

    int total = 0;
    int bad = 0;

    logic [9:0] sh_exp = '0;
    logic [7:0] exp_code [2];

    always #5 clk = ~clk;

    dpot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sck), .ser_din(din),
        .sleep_n(sleep_n), .ser_dout(dout), .wiper_code(code),
        .term_a_open(aopen), .wiper_to_b(wshort)
    );

    dpot_ctrl dut2 (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sck), .ser_din(dout),
        .sleep_n(sleep_n), .ser_dout(dout2), .wiper_code(code2),
        .term_a_open(aopen2), .wiper_to_b(wshort2)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sel_low();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    // Deselect; the model commits its frame per R2/R3
    task automatic sel_high();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
        exp_code[sh_exp[8]] = sh_exp[7:0];
    endtask

    task automatic shift_bit(input logic b, output logic so);
        din = b;
        wait_clk(HALF);
        so = dout;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
        sh_exp = {sh_exp[8:0], b};
    endtask

    task automatic write_frame(input logic [1:0] addr, input logic [7:0] c);
        logic [9:0] f;
        logic so;
        f = {addr, c};
        sel_low();
        for (int i = 9; i >= 0; i--) shift_bit(f[i], so);
        sel_high();
    endtask

    initial begin
        logic so;
        logic [19:0] pat;
        exp_code[0] = 8'h80;
        exp_code[1] = 8'h80;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(8);

        // R1: reset state
        chk("R1 codes", 32'(code), 32'h8080);
        chk("R1 dout", 32'(dout), 32'h0);
        chk("R9 awake switches", 32'({aopen, wshort}), 32'h0);

        // R2 R3 R4: every code on both channels, A1 toggled along the way
        for (int c = 0; c < 256; c++) begin
            for (int ch = 0; ch < 2; ch++) begin
                write_frame({1'(c[3] ^ ch[0]), 1'(ch)}, 8'(c));
                chk("R3 sweep", 32'(code), 32'({exp_code[1], exp_code[0]}));
            end
        end

        // R4: A1 set leaves selection and code unchanged
        write_frame(2'b10, 8'h3D);
        chk("R4 a1 ch0", 32'(code), 32'({exp_code[1], 8'h3D}));
        write_frame(2'b11, 8'hC2);
        chk("R4 a1 ch1", 32'(code), 32'h0000C23D);

        // R5: codes hold mid-frame
        begin
            logic [9:0] f;
            f = {2'b00, 8'hE7};
            sel_low();
            for (int i = 9; i >= 4; i--) shift_bit(f[i], so);
            chk("R5 mid frame", 32'(code), 32'h0000C23D);
            for (int i = 3; i >= 0; i--) shift_bit(f[i], so);
            wait_clk(8);
            chk("R5 before deselect", 32'(code), 32'h0000C23D);
            sel_high();
            chk("R2 commit", 32'(code), 32'h0000C2E7);
        end

        // R6: 14 bits, last ten form the frame {01, 0x4B}
        sel_low();
        pat = {6'b0, 4'b1110, 2'b01, 8'h4B};
        for (int i = 13; i >= 0; i--) shift_bit(pat[i], so);
        sel_high();
        chk("R6 long frame", 32'(code), 32'h00004BE7);

        // R7: clocks while deselected are ignored; empty select recommits
        write_frame(2'b00, 8'h5A);
        din = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
        din = 1'b0;
        wait_clk(4);
        chk("R7 no effect while idle", 32'(code), 32'h00004B5A);
        sel_low();
        sel_high();
        chk("R7 recommit held frame", 32'(code), 32'h00004B5A);

        // R8: chain output carries the held frame, then the new bits
        pat = {10'h2B7, 2'b01, 8'h96};
        sel_low();
        for (int i = 19; i >= 0; i--) begin
            logic e;
            e = sh_exp[9];
            shift_bit(pat[i], so);
            chk("R8 dout stream", 32'(so), 32'(e));
        end
        sel_high();
        chk("R8 commit after burst", 32'(code), 32'h0000965A);
        begin
            logic held;
            held = dout;
            for (int i = 0; i < 4; i++) begin
                wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
            end
            wait_clk(4);
            chk("R8 dout hold deselected", 32'(dout), 32'(held));
        end

        // R9 R10: sleep
        sleep_n = 1'b0;
        wait_clk(8);
        chk("R9 sleep switches", 32'({aopen, wshort}), 32'hF);
        chk("R10 codes kept in sleep", 32'(code), 32'h0000965A);
        write_frame(2'b00, 8'h11);
        chk("R10 write in sleep", 32'(code), 32'h00009611);
        chk("R9 still asleep", 32'({aopen, wshort}), 32'hF);
        sleep_n = 1'b1;
        wait_clk(8);
        chk("R9 wake switches", 32'({aopen, wshort}), 32'h0);
        chk("R10 codes after wake", 32'(code), 32'h00009611);

        // R11: daisy chain, far block first
        pat = {2'b01, 8'h3C, 2'b00, 8'hC3};
        sel_low();
        for (int i = 19; i >= 0; i--) shift_bit(pat[i], so);
        sel_high();
        chk("R11 near block ch0", 32'(code[7:0]), 32'hC3);
        chk("R11 far block ch1", 32'(code2[15:8]), 32'h3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule